// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty Flag

This block buffers 36-bit words between two independent clock domains in a 1024-entry store. The producer writes on the write clock. The consumer reads on the read clock. Each side is gated by a pair of enables, and an access happens only when both enables of that side are high. The pointers cross between the domains in Gray code through multi-flop synchronizers. The write side sees a full flag. The read side sees an active-low empty flag and an active-low almost-empty flag.

The almost-empty flag compares the number of words visible to the reader against an offset register. The flag can take one of two timings. In the immediate form it follows the read-side count directly. In the registered form it is taken from a flop on the read clock, so it trails the immediate form by one read edge. The offset and the timing choice are loaded together through a strobe in the read clock domain.

Top module: `dcfifo_ae`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rd_empty_n` and `rd_aempty_n` are 0 and `wr_full` is 0. The offset resets to 8 and the flag timing resets to immediate (`cfg_ae_sync` = 0).
- R2: A word is stored on a rising `wr_clk` edge only if both `wr_en_a` and `wr_en_b` are 1. With only one of them high, nothing is stored and the read side stays empty.
- R3: A word is taken on a rising `rd_clk` edge only if both `rd_en_a` and `rd_en_b` are 1. `rd_data` changes only on such an accepted read, and it then shows the oldest unread word. Otherwise it holds.
- R4: `rd_empty_n` is 0 exactly when the read side sees no stored words. With both clocks equal, a word written on edge k makes `rd_empty_n` go to 1 after edge k+2 and not before.
- R5: A read attempted while `rd_empty_n` is 0 is ignored: `rd_data` holds and no word is lost.
- R6: With `cfg_ae_sync` = 0, `rd_aempty_n` is 0 exactly when the visible count is at most the offset. It changes in the same edge as the count.
- R7: With `cfg_ae_sync` = 1, `rd_aempty_n` after each read edge equals the value the immediate form had just before that edge.
- R8: The store takes 1024 unread words and then raises `wr_full`. Writes while `wr_full` is 1 are dropped. Words come out in write order.
- R9: A `rd_clk` edge with `cfg_we` = 1 loads the offset from `cfg_offset` and the timing from `cfg_ae_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write clock |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | High when no location is free |
| rd_clk | input | 1 | Read clock |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | DATA_W | Last word read, registered |
| rd_empty_n | output | 1 | Low when no word is visible to the reader |
| rd_aempty_n | output | 1 | Low when the visible count is at most the offset |
| cfg_we | input | 1 | Load strobe for offset and timing, read domain |
| cfg_offset | input | ADDR_W+1 | Almost-empty offset value |
| cfg_ae_sync | input | 1 | 1 selects registered almost-empty timing |

## Verification
The bench goes after the exact edge on which a write becomes visible through the two-flop crossing. A design with a missing or extra stage would clear the empty flag one edge early or one edge late. It checks the almost-empty flag at count = offset + 1 and at count = offset, where an off-by-one comparison shows up as a flag that flips one read too early or too late. It also checks the registered timing, where a design would otherwise show the new value without the one-edge lag. Single-enable accesses, reads while empty and writes past the 1024th word are all driven. A design that ignored an enable or a flag would store or drop the wrong word, and the reference queue catches that on the next read.

// File: rtl/dcfifo_ae_pkg.sv
package dcfifo_ae_pkg;
   typedef enum logic {
      AE_IMMEDIATE  = 1'b0,
      AE_REGISTERED = 1'b1
   } ae_mode_e;
endpackage

// File: rtl/dcfifo_ae_sync.sv
module dcfifo_ae_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_ae_wrside.sv
module dcfifo_ae_wrside #(
   parameter int ADDR_W = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_a,
   input  logic          en_b,
   input  logic [ADDR_W:0] rd_gray_sync,
   output logic [ADDR_W:0] ptr_bin,
   output logic [ADDR_W:0] ptr_gray,
   output logic          accept,
   output logic          full
);
   localparam int PTR_W = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;

   logic [PTR_W-1:0] rd_bin;
   logic [PTR_W-1:0] ptr_next;

   always_comb begin
      rd_bin[PTR_W-1] = rd_gray_sync[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--)
         rd_bin[i] = rd_bin[i+1] ^ rd_gray_sync[i];
   end

   assign full     = (ptr_bin - rd_bin) == DEPTH;
   assign accept   = en_a && en_b && !full;
   assign ptr_next = ptr_bin + PTR_W'(accept);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr_bin  <= '0;
         ptr_gray <= '0;
      end else begin
         ptr_bin  <= ptr_next;
         ptr_gray <= ptr_next ^ (ptr_next >> 1);
      end
endmodule

// File: rtl/dcfifo_ae_rdside.sv
module dcfifo_ae_rdside
   import dcfifo_ae_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int AE_RESET = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_a,
   input  logic            en_b,
   input  logic [ADDR_W:0] wr_gray_sync,
   input  logic            cfg_we,
   input  logic [ADDR_W:0] cfg_offset,
   input  logic            cfg_ae_sync,
   output logic [ADDR_W:0] ptr_bin,
   output logic [ADDR_W:0] ptr_gray,
   output logic            accept,
   output logic            empty_n,
   output logic            aempty_n,
   output logic            mode_reg
);
   localparam int PTR_W = ADDR_W + 1;

   logic [PTR_W-1:0] wr_bin;
   logic [PTR_W-1:0] level;
   logic [PTR_W-1:0] offset_q;
   logic [PTR_W-1:0] ptr_next;
   ae_mode_e         mode_q;
   logic             ae_imm_n;
   logic             ae_reg_n;

   always_comb begin
      wr_bin[PTR_W-1] = wr_gray_sync[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--)
         wr_bin[i] = wr_bin[i+1] ^ wr_gray_sync[i];
   end

   assign level    = wr_bin - ptr_bin;
   assign empty_n  = level != '0;
   assign accept   = en_a && en_b && empty_n;
   assign ptr_next = ptr_bin + PTR_W'(accept);
   assign ae_imm_n = level > offset_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr_bin  <= '0;
         ptr_gray <= '0;
         ae_reg_n <= 1'b0;
         offset_q <= PTR_W'(AE_RESET);
         mode_q   <= AE_IMMEDIATE;
      end else begin
         ptr_bin  <= ptr_next;
         ptr_gray <= ptr_next ^ (ptr_next >> 1);
         ae_reg_n <= ae_imm_n;
         if (cfg_we) begin
            offset_q <= cfg_offset;
            mode_q   <= cfg_ae_sync ? AE_REGISTERED : AE_IMMEDIATE;
         end
      end

   assign aempty_n = (mode_q == AE_REGISTERED) ? ae_reg_n : ae_imm_n;
   assign mode_reg = mode_q == AE_REGISTERED;
endmodule

// File: rtl/dcfifo_ae.sv
module dcfifo_ae #(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   parameter int AE_RESET    = 8
) (
   input  logic              rst_n,
   input  logic              wr_clk,
   input  logic              wr_en_a,
   input  logic              wr_en_b,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_en_a,
   input  logic              rd_en_b,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty_n,
   output logic              rd_aempty_n,
   input  logic              cfg_we,
   input  logic [ADDR_W:0]   cfg_offset,
   input  logic              cfg_ae_sync
);
   localparam int PTR_W = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W < 1)      begin : g_bad_data  $error("DATA_W must be at least 1");  end
   if (ADDR_W < 2)      begin : g_bad_addr  $error("ADDR_W must be at least 2");  end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be >= 2");   end
   if (AE_RESET < 0 || AE_RESET > DEPTH)
                        begin : g_bad_ae    $error("AE_RESET out of range");      end

   logic [PTR_W-1:0]  wr_ptr_bin, wr_ptr_gray, rd_ptr_bin, rd_ptr_gray;
   logic [PTR_W-1:0]  wr_gray_at_rd, rd_gray_at_wr;
   logic              wr_accept, rd_accept, mode_sync;
   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] rd_data_q;

   dcfifo_ae_wrside #(.ADDR_W(ADDR_W)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
      .rd_gray_sync(rd_gray_at_wr), .ptr_bin(wr_ptr_bin),
      .ptr_gray(wr_ptr_gray), .accept(wr_accept), .full(wr_full));

   dcfifo_ae_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wr_ptr_gray), .q(wr_gray_at_rd));

   dcfifo_ae_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rd_ptr_gray), .q(rd_gray_at_wr));

   dcfifo_ae_rdside #(.ADDR_W(ADDR_W), .AE_RESET(AE_RESET)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b),
      .wr_gray_sync(wr_gray_at_rd), .cfg_we(cfg_we), .cfg_offset(cfg_offset),
      .cfg_ae_sync(cfg_ae_sync), .ptr_bin(rd_ptr_bin), .ptr_gray(rd_ptr_gray),
      .accept(rd_accept), .empty_n(rd_empty_n), .aempty_n(rd_aempty_n),
      .mode_reg(mode_sync));

   always_ff @(posedge wr_clk)
      if (wr_accept) store[wr_ptr_bin[ADDR_W-1:0]] <= wr_data;

   always_ff @(posedge rd_clk or negedge rst_n)
      if (!rst_n)         rd_data_q <= '0;
      else if (rd_accept) rd_data_q <= store[rd_ptr_bin[ADDR_W-1:0]];

   assign rd_data = rd_data_q;
endmodule

// File: rtl/dcfifo_ae_chk.sv
module dcfifo_ae_chk #(
   parameter int DATA_W = 36,
   parameter int PTR_W  = 11
) (
   input logic              rst_n,
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              wr_en_a,
   input logic              wr_en_b,
   input logic              rd_en_a,
   input logic              rd_en_b,
   input logic              wr_full,
   input logic              rd_empty_n,
   input logic              rd_aempty_n,
   input logic              mode_sync,
   input logic [DATA_W-1:0] rd_data,
   input logic [PTR_W-1:0]  wr_ptr_bin,
   input logic [PTR_W-1:0]  rd_ptr_bin
);
   a_r2_single_enable_no_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !(wr_en_a && wr_en_b) |=> $stable(wr_ptr_bin));

   a_r8_no_write_when_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_full |=> $stable(wr_ptr_bin));

   a_r3_hold_without_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !(rd_en_a && rd_en_b) |=> $stable(rd_data) && $stable(rd_ptr_bin));

   a_r5_no_read_when_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_empty_n |=> $stable(rd_data) && $stable(rd_ptr_bin));

   a_r6_empty_implies_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!mode_sync && !rd_empty_n) |-> !rd_aempty_n);
endmodule

bind dcfifo_ae dcfifo_ae_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
   .rst_n(rst_n), .wr_clk(wr_clk), .rd_clk(rd_clk),
   .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
   .wr_full(wr_full), .rd_empty_n(rd_empty_n), .rd_aempty_n(rd_aempty_n),
   .mode_sync(mode_sync), .rd_data(rd_data),
   .wr_ptr_bin(wr_ptr_bin), .rd_ptr_bin(rd_ptr_bin));

// File: tb/dcfifo_ae_bench.sv
module dcfifo_ae_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0;
   logic [35:0] wr_data = '0;
   logic        cfg_we = 0, cfg_ae_sync = 0;
   logic [10:0] cfg_offset = '0;
   logic        wr_full, rd_empty_n, rd_aempty_n;
   logic [35:0] rd_data;

   int n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   dcfifo_ae u_dcfifo_ae (
      .rst_n(rst_n), .wr_clk(clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b),
      .wr_data(wr_data), .wr_full(wr_full), .rd_clk(clk), .rd_en_a(rd_en_a),
      .rd_en_b(rd_en_b), .rd_data(rd_data), .rd_empty_n(rd_empty_n),
      .rd_aempty_n(rd_aempty_n), .cfg_we(cfg_we), .cfg_offset(cfg_offset),
      .cfg_ae_sync(cfg_ae_sync));

   function automatic logic [35:0] pat(int i);
      return {4'hA, 32'(i * 7 + 3)};
   endfunction

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model, one clock drives both sides
   logic [10:0] m_wp, m_rp, m_ws1, m_ws2, m_rs1, m_rs2, m_q, m_cnt;
   logic        m_ms, m_aeq, m_aec, m_wacc, m_racc, m_full;
   logic [35:0] m_rd;
   logic [35:0] m_fifo [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wp = 0; m_rp = 0; m_ws1 = 0; m_ws2 = 0; m_rs1 = 0; m_rs2 = 0;
         m_q = 11'd8; m_ms = 0; m_aeq = 0; m_rd = '0; m_fifo.delete();
      end else begin
         m_full = (m_wp - m_rs2) == 11'd1024;
         m_cnt  = m_ws2 - m_rp;
         m_wacc = wr_en_a && wr_en_b && !m_full;
         m_racc = rd_en_a && rd_en_b && (m_cnt != 0);
         m_aec  = m_cnt > m_q;
         if (m_racc) m_rd = m_fifo.pop_front();
         if (m_wacc) m_fifo.push_back(wr_data);
         m_aeq = m_aec;
         if (cfg_we) begin m_q = cfg_offset; m_ms = cfg_ae_sync; end
         m_ws2 = m_ws1; m_ws1 = m_wp; m_rs2 = m_rs1; m_rs1 = m_rp;
         m_wp = m_wp + 11'(m_wacc);
         m_rp = m_rp + 11'(m_racc);
      end
      #2;
      if (rst_n) begin
         m_cnt = m_ws2 - m_rp;
         check("R8", 36'(wr_full), 36'((m_wp - m_rs2) == 11'd1024));
         check("R4", 36'(rd_empty_n), 36'(m_cnt != 0));
         if (m_ms) check("R7", 36'(rd_aempty_n), 36'(m_aeq));
         else      check("R6", 36'(rd_aempty_n), 36'(m_cnt > m_q));
         check("R3", rd_data, m_rd);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_n(int first, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en_a = 1; wr_en_b = 1; wr_data = pat(first + i);
      end
      @(negedge clk);
      wr_en_a = 0; wr_en_b = 0;
   endtask

   task automatic read_one;
      @(negedge clk);
      rd_en_a = 1; rd_en_b = 1;
      @(negedge clk);
      rd_en_a = 0; rd_en_b = 0;
   endtask

   task automatic load_cfg(input logic [10:0] off, input logic sync);
      @(negedge clk);
      cfg_we = 1; cfg_offset = off; cfg_ae_sync = sync;
      @(negedge clk);
      cfg_we = 0;
   endtask

   bit done = 0;
   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      check("R1 empty", 36'(rd_empty_n), 36'(0));
      check("R1 aempty", 36'(rd_aempty_n), 36'(0));
      check("R1 full", 36'(wr_full), 36'(0));
      rst_n = 1;
      step(2);
      check("R1 after release", 36'(rd_empty_n), 36'(0));

      // R2 single enable does not store
      @(negedge clk); wr_en_a = 1; wr_data = pat(900);
      step(3); wr_en_a = 0; wr_en_b = 1;
      step(3); wr_en_b = 0;
      step(4);
      check("R2", 36'(rd_empty_n), 36'(0));

      // R4 crossing latency: write on edge k, visible after edge k+2
      @(negedge clk); wr_en_a = 1; wr_en_b = 1; wr_data = pat(0);
      @(negedge clk); wr_en_a = 0; wr_en_b = 0;
      check("R4 k", 36'(rd_empty_n), 36'(0));
      @(negedge clk);
      check("R4 k+1", 36'(rd_empty_n), 36'(0));
      @(negedge clk);
      check("R4 k+2", 36'(rd_empty_n), 36'(1));

      // R3 single read enable does nothing; both enables read
      @(negedge clk); rd_en_a = 1;
      step(3); rd_en_a = 0;
      check("R3 hold", rd_data, 36'(0));
      read_one();
      check("R3 read", rd_data, pat(0));
      check("R3 empty after", 36'(rd_empty_n), 36'(0));

      // R5 read while empty is ignored
      @(negedge clk); rd_en_a = 1; rd_en_b = 1;
      step(4); rd_en_a = 0; rd_en_b = 0;
      check("R5 hold", rd_data, pat(0));
      write_n(1, 1);
      step(4);
      read_one();
      check("R5 next word", rd_data, pat(1));

      // R6 boundary at offset 8
      write_n(10, 10);
      step(4);
      check("R6 count10", 36'(rd_aempty_n), 36'(1));
      read_one();
      check("R6 count9", 36'(rd_aempty_n), 36'(1));
      read_one();
      check("R6 count8", 36'(rd_aempty_n), 36'(0));

      // R9 load offset 3, immediate timing
      load_cfg(11'd3, 1'b0);
      check("R9 offset3", 36'(rd_aempty_n), 36'(1));

      // R7 registered timing lags by one edge
      load_cfg(11'd3, 1'b1);
      step(2);
      for (int i = 0; i < 4; i++) read_one();   // count 8 -> 4
      check("R7 count4", 36'(rd_aempty_n), 36'(1));
      @(negedge clk); rd_en_a = 1; rd_en_b = 1;
      @(negedge clk); rd_en_a = 0; rd_en_b = 0;  // count 3 now
      check("R7 lag", 36'(rd_aempty_n), 36'(1));
      @(negedge clk);
      check("R7 settled", 36'(rd_aempty_n), 36'(0));

      // drain, restore immediate timing
      load_cfg(11'd8, 1'b0);
      @(negedge clk); rd_en_a = 1; rd_en_b = 1;
      step(6); rd_en_a = 0; rd_en_b = 0;
      check("R8 drained", 36'(rd_empty_n), 36'(0));

      // R8 fill past capacity, then drain in order
      write_n(2000, 1030);
      step(4);
      check("R8 full", 36'(wr_full), 36'(1));
      @(negedge clk); rd_en_a = 1; rd_en_b = 1;
      step(1100); rd_en_a = 0; rd_en_b = 0;
      check("R8 last kept", rd_data, pat(2000 + 1023));
      check("R8 empty", 36'(rd_empty_n), 36'(0));
      check("R8 model empty", 36'(m_fifo.size()), 36'(0));

      step(3);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule